// File: doc/BRIEF.md
# DMA Page Register File

This block widens the 16-bit addresses produced by a DMA controller. Each of four channels owns a 16-bit page value. Software reaches that value one byte at a time through two byte windows. The low-page window carries bits 7:0 and the high-page window carries bits 15:8. The low-page window is 16 bytes wide and is split into two banks of eight slots. Only four slots in each bank hold page bytes, and they map onto channels in a fixed order that is not linear. The other slots act as plain scratch storage.

On the controller side, the block takes the number of the active channel and the controller's 16-bit offset. It returns a 32-bit physical address. That address is built from the bank-0 page of the channel, limited to 31 bits, with the offset placed in the low half. Writes are registered on the clock. Reads and the composed address are combinational.

Top module: `dma_page_regs`

## Requirements
- R1: A window offset selects its bank with bit 3 (0 = bank 0, 1 = bank 1) and its slot with bits 2:0.
- R2: Slots map to channels in this order: slot 1 → channel 2, slot 2 → channel 3, slot 3 → channel 1, slot 7 → channel 0. Slots 0, 4, 5 and 6 hold no page byte.
- R3: A write to the low-page window (`win_hi` = 0) at a mapped slot replaces bits 7:0 of that bank's channel page and leaves bits 15:8 unchanged.
- R4: A write to the high-page window (`win_hi` = 1) at a mapped slot replaces bits 15:8 and leaves bits 7:0 unchanged. A high-page write at an unmapped slot changes nothing.
- R5: Every low-page write, mapped or not, also stores its byte in a 16-entry scratch array indexed by offset bits 3:0. A low-page read at an unmapped slot returns that scratch byte.
- R6: A low-page read at a mapped slot returns bits 7:0 of that bank's channel page.
- R7: Any read of the high-page window returns 0x00.
- R8: `phys_addr` equals ((bank-0 page of `dma_chan` shifted left by 16) AND 0x7FFF0000) plus `dma_off`. Page bit 15 therefore never reaches the address.
- R9: Reset clears every page register and every scratch byte to zero.
- R10: Bank-1 page values have no effect on `phys_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe, sampled on the rising edge |
| win_hi | input | 1 | Window select: 0 = low-page bytes, 1 = high-page bytes |
| win_off | input | 4 | Byte offset inside the window |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for `win_hi`/`win_off` (combinational) |
| dma_chan | input | 2 | Active DMA channel |
| dma_off | input | 16 | Controller's 16-bit address offset |
| phys_addr | output | 32 | Composed physical address |

## Verification
Low-page and high-page bytes are written in a mixed order, so a design that clears the other half of the page on a write gives wrong composed addresses. Every channel's address is then checked with distinct offsets. A value written with page bit 15 set shows whether the 31-bit mask is applied. Bank-1 writes that reuse bank-0 slot numbers show whether the bank bit is ignored. Reading back all 16 low offsets separates mapped slots from scratch slots and catches a permuted channel order. A high-page write to an unmapped slot must leave every readback and address as it was.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;
  localparam int SLOT_W = 3;
  localparam int CH_W   = 2;

  typedef struct packed {
    logic            hit;
    logic [CH_W-1:0] chan;
  } slot_map_t;

  // Fixed slot-to-channel order; unmapped slots report hit = 0.
  function automatic slot_map_t map_slot(input logic [SLOT_W-1:0] slot);
    slot_map_t m;
    m = '0;
    case (slot)
      3'd1: begin m.hit = 1'b1; m.chan = 2'd2; end
      3'd2: begin m.hit = 1'b1; m.chan = 2'd3; end
      3'd3: begin m.hit = 1'b1; m.chan = 2'd1; end
      3'd7: begin m.hit = 1'b1; m.chan = 2'd0; end
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/dma_page_decode.sv
module dma_page_decode
  import dma_page_pkg::*;
#(
  parameter int OFFS_W = 4
) (
  input  logic [OFFS_W-1:0] win_off,
  output logic              bank,
  output logic              hit,
  output logic [CH_W-1:0]   chan
);
  slot_map_t m;

  always_comb begin
    m    = map_slot(win_off[SLOT_W-1:0]);
    bank = win_off[SLOT_W];
    hit  = m.hit;
    chan = m.chan;
  end
endmodule

// File: rtl/dma_page_store.sv
module dma_page_store
  import dma_page_pkg::*;
#(
  parameter int NBANK  = 2,
  parameter int NCH    = 4,
  parameter int BYTE_W = 8,
  parameter int OFFS_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lo_wr,
  input  logic                      hi_wr,
  input  logic [OFFS_W-1:0]         win_off,
  input  logic                      win_hi,
  input  logic                      bank,
  input  logic                      hit,
  input  logic [CH_W-1:0]           chan,
  input  logic [BYTE_W-1:0]         wr_data,
  input  logic [CH_W-1:0]           addr_chan,
  output logic [BYTE_W-1:0]         rd_data,
  output logic [2*BYTE_W-1:0]       addr_page,
  output logic [(NBANK*NCH+(1<<OFFS_W))*BYTE_W-1:0] lo_view,
  output logic [NBANK*NCH*BYTE_W-1:0] hi_view
);
  localparam int PAGE_W = 2 * BYTE_W;
  localparam int NPAGE  = NBANK * NCH;
  localparam int NSCR   = 1 << OFFS_W;

  logic [NPAGE*PAGE_W-1:0] pg_flat;
  logic [NSCR*BYTE_W-1:0]  scr_flat;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [PAGE_W-1:0] q;
      logic sel;
      assign sel = hit && (bank == b[0]) && (chan == c[CH_W-1:0]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else begin
          if (lo_wr && sel) q[BYTE_W-1:0]      <= wr_data;
          if (hi_wr && sel) q[PAGE_W-1:BYTE_W] <= wr_data;
        end
      end
      assign pg_flat[(b*NCH+c)*PAGE_W +: PAGE_W] = q;
      assign lo_view[(b*NCH+c)*BYTE_W +: BYTE_W] = q[BYTE_W-1:0];
      assign hi_view[(b*NCH+c)*BYTE_W +: BYTE_W] = q[PAGE_W-1:BYTE_W];
    end
  end

  for (genvar i = 0; i < NSCR; i++) begin : g_scr
    logic [BYTE_W-1:0] s;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   s <= '0;
      else if (lo_wr && win_off == i[OFFS_W-1:0])  s <= wr_data;
    end
    assign scr_flat[i*BYTE_W +: BYTE_W] = s;
  end

  assign lo_view[NPAGE*BYTE_W +: NSCR*BYTE_W] = scr_flat;

  logic [$clog2(NPAGE)-1:0] rd_idx;
  assign rd_idx = {bank, chan};

  always_comb begin
    if (win_hi)   rd_data = '0;
    else if (hit) rd_data = pg_flat[rd_idx*PAGE_W +: BYTE_W];
    else          rd_data = scr_flat[win_off*BYTE_W +: BYTE_W];
  end

  // Bank 0 alone drives address composition.
  assign addr_page = pg_flat[addr_chan*PAGE_W +: PAGE_W];
endmodule

// File: rtl/dma_page_compose.sv
module dma_page_compose #(
  parameter int          PAGE_W    = 16,
  parameter int          CO_W      = 16,
  parameter logic [31:0] ADDR_MASK = 32'h7FFF_0000
) (
  input  logic [PAGE_W-1:0]      page,
  input  logic [CO_W-1:0]        dma_off,
  output logic [PAGE_W+CO_W-1:0] phys_addr
);
  localparam int ADDR_W = PAGE_W + CO_W;

  function automatic logic [ADDR_W-1:0] compose(input logic [PAGE_W-1:0] p,
                                                input logic [CO_W-1:0]   o);
    logic [ADDR_W-1:0] base;
    base = {p, {CO_W{1'b0}}} & ADDR_MASK[ADDR_W-1:0];
    return base + {{PAGE_W{1'b0}}, o};
  endfunction

  assign phys_addr = compose(page, dma_off);
endmodule

// File: rtl/dma_page_regs.sv
module dma_page_regs
  import dma_page_pkg::*;
#(
  parameter int NBANK  = 2,
  parameter int NCH    = 4,
  parameter int BYTE_W = 8,
  parameter int OFFS_W = 4,
  parameter int CO_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     win_hi,
  input  logic [OFFS_W-1:0]        win_off,
  input  logic [BYTE_W-1:0]        wr_data,
  output logic [BYTE_W-1:0]        rd_data,
  input  logic [CH_W-1:0]          dma_chan,
  input  logic [CO_W-1:0]          dma_off,
  output logic [2*BYTE_W+CO_W-1:0] phys_addr
);
  localparam int PAGE_W = 2 * BYTE_W;
  localparam int NSCR   = 1 << OFFS_W;

  logic            dec_bank;
  logic            dec_hit;
  logic [CH_W-1:0] dec_chan;
  logic            lo_wr_evt;
  logic            hi_wr_evt;
  logic [PAGE_W-1:0] addr_page;
  logic [(NBANK*NCH+NSCR)*BYTE_W-1:0] lo_view;
  logic [NBANK*NCH*BYTE_W-1:0]        hi_view;

  assign lo_wr_evt = wr_en && !win_hi;
  assign hi_wr_evt = wr_en && win_hi && dec_hit;

  dma_page_decode #(.OFFS_W(OFFS_W)) u_dec (
    .win_off (win_off),
    .bank    (dec_bank),
    .hit     (dec_hit),
    .chan    (dec_chan)
  );

  dma_page_store #(
    .NBANK(NBANK), .NCH(NCH), .BYTE_W(BYTE_W), .OFFS_W(OFFS_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .lo_wr     (lo_wr_evt),
    .hi_wr     (hi_wr_evt),
    .win_off   (win_off),
    .win_hi    (win_hi),
    .bank      (dec_bank),
    .hit       (dec_hit),
    .chan      (dec_chan),
    .wr_data   (wr_data),
    .addr_chan (dma_chan),
    .rd_data   (rd_data),
    .addr_page (addr_page),
    .lo_view   (lo_view),
    .hi_view   (hi_view)
  );

  dma_page_compose #(.PAGE_W(PAGE_W), .CO_W(CO_W)) u_comp (
    .page      (addr_page),
    .dma_off   (dma_off),
    .phys_addr (phys_addr)
  );
endmodule

// File: rtl/dma_page_regs_chk.sv
module dma_page_regs_chk #(
  parameter int BYTE_W = 8,
  parameter int OFFS_W = 4,
  parameter int CO_W   = 16,
  parameter int LO_W   = 192,
  parameter int HI_W   = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic                     win_hi,
  input logic [OFFS_W-1:0]        win_off,
  input logic [BYTE_W-1:0]        wr_data,
  input logic [BYTE_W-1:0]        rd_data,
  input logic [CO_W-1:0]          dma_off,
  input logic [2*BYTE_W+CO_W-1:0] phys_addr,
  input logic                     lo_wr_evt,
  input logic                     hi_wr_evt,
  input logic [LO_W-1:0]          lo_view,
  input logic [HI_W-1:0]          hi_view
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_LO_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(wr_en) && !$past(win_hi) && !wr_en && !win_hi && win_off == $past(win_off))
      |-> rd_data == $past(wr_data)); // R5

  AST_LO_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && lo_wr_evt) |=> $stable(hi_view)); // R3

  AST_HI_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && hi_wr_evt) |=> $stable(lo_view)); // R4

  AST_HI_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_en && win_hi && !hi_wr_evt) |=> ($stable(hi_view) && $stable(lo_view))); // R4

  AST_HI_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    win_hi |-> rd_data == '0); // R7

  AST_ADDR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (phys_addr[CO_W-1:0] == dma_off) && !phys_addr[2*BYTE_W+CO_W-1]); // R8
endmodule

bind dma_page_regs dma_page_regs_chk #(
  .BYTE_W(BYTE_W), .OFFS_W(OFFS_W), .CO_W(CO_W),
  .LO_W((NBANK*NCH+(1<<OFFS_W))*BYTE_W), .HI_W(NBANK*NCH*BYTE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .win_hi    (win_hi),
  .win_off   (win_off),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .dma_off   (dma_off),
  .phys_addr (phys_addr),
  .lo_wr_evt (lo_wr_evt),
  .hi_wr_evt (hi_wr_evt),
  .lo_view   (lo_view),
  .hi_view   (hi_view)
);

// File: tb/dma_page_regs_test.sv
module dma_page_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        win_hi = 1'b0;
  logic [3:0]  win_off = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [1:0]  dma_chan = '0;
  logic [15:0] dma_off = '0;
  logic [31:0] phys_addr;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_pg [2][4];
  logic [7:0]  m_scr [16];

  always #2 clk = ~clk;

  dma_page_regs uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .win_hi(win_hi),
    .win_off(win_off), .wr_data(wr_data), .rd_data(rd_data),
    .dma_chan(dma_chan), .dma_off(dma_off), .phys_addr(phys_addr)
  );

  // Stimulus table: {win_hi, offset[3:0], byte}
  localparam logic [12:0] VEC [13] = '{
    {1'b0, 4'd7,  8'h12}, {1'b1, 4'd1,  8'h34}, {1'b0, 4'd1,  8'h56},
    {1'b1, 4'd7,  8'hAB}, {1'b0, 4'd3,  8'h9A}, {1'b1, 4'd2,  8'h7E},
    {1'b0, 4'd2,  8'hC3}, {1'b1, 4'd3,  8'h01}, {1'b0, 4'd0,  8'h5A},
    {1'b0, 4'd9,  8'hEE}, {1'b1, 4'd15, 8'h66}, {1'b0, 4'd12, 8'h77},
    {1'b1, 4'd4,  8'h99}
  };

  // Slot order from R2; -1 marks an unmapped slot.
  function automatic int chan_of(input int slot);
    case (slot)
      1: return 2;
      2: return 3;
      3: return 1;
      7: return 0;
      default: return -1;
    endcase
  endfunction

  task automatic model_clear();
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 4; c++) m_pg[b][c] = 16'h0;
    for (int i = 0; i < 16; i++) m_scr[i] = 8'h0;
  endtask

  task automatic model_write(input logic hi, input int off, input logic [7:0] d);
    int ch;
    int bk;
    ch = chan_of(off % 8);
    bk = off / 8;
    if (!hi) begin
      m_scr[off] = d;
      if (ch >= 0) m_pg[bk][ch] = {m_pg[bk][ch][15:8], d};
    end else if (ch >= 0) begin
      m_pg[bk][ch] = {d, m_pg[bk][ch][7:0]};
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic hi, input int off, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; win_hi = hi; win_off = off[3:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(hi, off, d);
  endtask

  task automatic check_addr(input int ch, input logic [15:0] off, input string req);
    logic [31:0] exp;
    @(negedge clk);
    dma_chan = ch[1:0]; dma_off = off;
    #1;
    exp = {1'b0, m_pg[0][ch][14:0], off};
    check(phys_addr === exp, req, phys_addr, exp);
  endtask

  task automatic check_rd(input logic hi, input int off, input string req);
    logic [7:0] exp;
    int ch;
    @(negedge clk);
    win_hi = hi; win_off = off[3:0];
    #1;
    ch = chan_of(off % 8);
    if (hi)           exp = 8'h00;
    else if (ch >= 0) exp = m_pg[off / 8][ch][7:0];
    else              exp = m_scr[off];
    check(rd_data === exp, req, {24'h0, rd_data}, {24'h0, exp});
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    for (int c = 0; c < 4; c++) check_addr(c, 16'h1234, "R9 reset addr");
    for (int i = 0; i < 16; i++) check_rd(1'b0, i, "R9 reset read");

    // Table walk: mixed low/high ordering (R1 R2 R3 R4 R5)
    for (int k = 0; k < 13; k++) wr(VEC[k][12], int'(VEC[k][11:8]), VEC[k][7:0]);

    // R8 composition per channel, R3/R4 both halves kept
    check_addr(0, 16'h0000, "R8 ch0 masked bit15");
    check_addr(1, 16'hBEEF, "R8 R3 R4 ch1");
    check_addr(2, 16'h8001, "R8 R2 ch2");
    check_addr(3, 16'hFFFF, "R8 R2 ch3");

    // R5 R6 R1 full low readback, R7 high reads
    for (int i = 0; i < 16; i++) check_rd(1'b0, i, "R5 R6 R1 low readback");
    check_rd(1'b1, 7, "R7 high read mapped");
    check_rd(1'b1, 4, "R7 high read unmapped");

    // R10 bank-1 page change leaves addresses alone
    wr(1'b1, 10, 8'h3C);
    wr(1'b0, 11, 8'hD2);
    for (int c = 0; c < 4; c++) check_addr(c, 16'h4242, "R10 bank1 isolated");
    check_rd(1'b0, 11, "R6 R1 bank1 slot3");

    // R4 high write to unmapped slot: nothing changes
    wr(1'b1, 5, 8'hF0);
    for (int c = 0; c < 4; c++) check_addr(c, 16'h0101, "R4 unmapped high ignored");
    check_rd(1'b0, 5, "R4 R5 unmapped high ignored");

    // R3 low rewrite keeps high byte; boundary page 7FFF/FFFF
    wr(1'b0, 1, 8'hFF);
    wr(1'b1, 1, 8'hFF);
    check_addr(2, 16'hFFFF, "R8 R3 top boundary");

    // R9 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) check_addr(c, 16'h00FF, "R9 reset clears pages");
    check_rd(1'b0, 12, "R9 reset clears scratch");

    summary();
  end
endmodule